// File: doc/BRIEF.md
# Multi-Rate Sample Capture Buffer

This block sits behind a logic-analyzer style sampling front end. Every clock it receives one word of sampled probe channels and, depending on a rate setting, writes one storage entry per clock (full channel width) or packs the narrower channel group of two or four successive clocks into one entry. In the packed settings fewer channels are kept, but each kept channel is recorded on every clock while the buffer fills at half or a quarter of the clock rate. Each stored entry carries a wide free-running timestamp counted in clock ticks. One tick stands for 125 ps when the sample clock runs at 8 GHz.

Entries go into an on-chip circular buffer. Storage runs either continuously or only for groups that a trigger controller qualifies. A trigger input records the write address so that software can separate the data before the trigger from the data after it. An arm input starts an acquisition: it latches the rate setting and clears the timestamp and the buffer pointers. A registered read port returns any entry with its timestamp.

Top module: `msc_capture`

## Requirements
- R1: A rising edge on `arm_i` (high while it was low on the previous clock) latches the rate code and clears the timestamp, `wr_ptr_o`, `wrapped_o`, `trig_seen_o` and `trig_addr_o`. `running_o` is high from the next cycle for as long as `arm_i` stays high. When `arm_i` goes low, `running_o` drops after the next edge and any partly collected group is thrown away.
- R2: Rate codes on `rate_i` are 0 = full width, 1 = double, 2 = quadruple. Code 3 acts as full width. Changing `rate_i` while running has no effect until the next arm.
- R3: In full-width mode, each stored clock writes the whole `sample_i` word as one entry.
- R4: In double mode, only channels [CH_W/2-1:0] are kept. Two successive sub-samples form one entry: the earlier one in bits [CH_W/2-1:0], the later one in bits [CH_W-1:CH_W/2].
- R5: In quadruple mode, only channels [CH_W/4-1:0] are kept. Sub-sample k (k = 0..3, oldest first) of a group sits in bits [k*CH_W/4 +: CH_W/4].
- R6: The clock after the arm edge has stamp 0. The stamp rises by one per clock while running and wraps to 0 modulo 2^TS_W. An entry stores the stamp of its first sub-sample, and sub-sample k of that entry has stamp base + k.
- R7: With `cont_i` high, every group is stored. With `cont_i` low, a group starts only on a running clock where `qual_i` is high. A group that has started completes whatever `qual_i` does.
- R8: Entries are written at consecutive addresses starting at 0 and wrap from DEPTH-1 to 0. `wr_ptr_o` shows the next address to be written, and `wrapped_o` sets at the first wrap.
- R9: The first `trig_i` on a running clock copies the `wr_ptr_o` value of that clock into `trig_addr_o` and sets `trig_seen_o`. An entry completing on the same clock therefore counts as pre-trigger. Later triggers, and triggers while idle, are ignored.
- R10: `rd_addr_i` is sampled at a clock edge. The entry's data and stamp appear on `rd_data_o` and `rd_stamp_o` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Acquisition enable; its rising edge starts a run |
| rate_i | input | 2 | Rate code, latched at arm |
| cont_i | input | 1 | 1 = store every group, 0 = store qualified groups |
| qual_i | input | 1 | Store qualifier from the trigger controller |
| trig_i | input | 1 | Trigger event |
| sample_i | input | CH_W | Sampled channel word |
| rd_addr_i | input | AW | Read address |
| running_o | output | 1 | Acquisition active |
| wr_ptr_o | output | AW | Next write address |
| wrapped_o | output | 1 | Buffer has wrapped since arm |
| trig_seen_o | output | 1 | Trigger recorded since arm |
| trig_addr_o | output | AW | Write address at the trigger |
| rd_data_o | output | CH_W | Packed sample data read back |
| rd_stamp_o | output | TS_W | Timestamp read back |

## Verification
Random sample words are run through each rate code with continuous storage, so that lane placement and per-entry stamps can be told apart for full, double and quadruple packing. Random qualifier patterns with `cont_i` low show whether gating is decided only at a group start and whether gaps appear in the stored stamps. Directed cases cover an arm drop in the middle of a group, a rate change during a run, code 3, idle and repeated triggers, and a run longer than the buffer, which checks the wrap and a trigger placed after it.

// File: rtl/msc_pkg.sv
`timescale 1ns/1ps
package msc_pkg;

  typedef enum logic [1:0] {
    RATE_X1 = 2'd0,
    RATE_X2 = 2'd1,
    RATE_X4 = 2'd2
  } rate_e;

  // Code 3 is unused and falls back to full width.
  function automatic rate_e rate_decode(logic [1:0] code);
    case (code)
      2'd1:    return RATE_X2;
      2'd2:    return RATE_X4;
      default: return RATE_X1;
    endcase
  endfunction

  // Index of the final sub-sample in a group.
  function automatic logic [1:0] last_slot(rate_e r);
    case (r)
      RATE_X2: return 2'd1;
      RATE_X4: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/msc_arm_ctrl.sv
`timescale 1ns/1ps
module msc_arm_ctrl
  import msc_pkg::*;
#(
  parameter int TS_W = 51
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            arm_i,
  input  logic [1:0]      rate_i,
  output logic            start_o,
  output logic            active_o,
  output logic            running_o,
  output rate_e           rate_o,
  output logic [TS_W-1:0] ts_o
);

  logic            arm_d;
  logic            run_q;
  rate_e           rate_q;
  logic [TS_W-1:0] ts_q;

  assign start_o   = arm_i & ~arm_d;
  assign active_o  = run_q & arm_i;
  assign running_o = run_q;
  assign rate_o    = rate_q;
  assign ts_o      = ts_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_d  <= 1'b0;
      run_q  <= 1'b0;
      rate_q <= RATE_X1;
      ts_q   <= '0;
    end else begin
      arm_d <= arm_i;
      if (start_o) begin
        run_q  <= 1'b1;
        rate_q <= rate_decode(rate_i);
        ts_q   <= '0;
      end else if (!arm_i) begin
        run_q <= 1'b0;
      end else if (run_q) begin
        ts_q <= ts_q + 1'b1;  // wraps silently
      end
    end
  end

endmodule

// File: rtl/msc_lane_packer.sv
`timescale 1ns/1ps
module msc_lane_packer
  import msc_pkg::*;
#(
  parameter int CH_W = 32,
  parameter int TS_W = 51
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            active_i,
  input  rate_e           rate_i,
  input  logic            cont_i,
  input  logic            qual_i,
  input  logic [CH_W-1:0] sample_i,
  input  logic [TS_W-1:0] ts_i,
  output logic            we_o,
  output logic [CH_W-1:0] wdata_o,
  output logic [TS_W-1:0] wstamp_o
);

  localparam int HW = CH_W / 2;
  localparam int QW = CH_W / 4;

  logic [1:0]      slot_q;
  logic [CH_W-1:0] pack_q;
  logic [TS_W-1:0] ts0_q;
  logic [CH_W-1:0] lane_x2, lane_x4, placed, pack_nxt;
  logic            go, last;

  // Steer the narrow channel group into the lane of the current slot.
  for (genvar k = 0; k < 2; k++) begin : g_half
    assign lane_x2[k*HW +: HW] = (int'(slot_q[0]) == k) ? sample_i[HW-1:0] : '0;
  end
  for (genvar k = 0; k < 4; k++) begin : g_quarter
    assign lane_x4[k*QW +: QW] = (int'(slot_q) == k) ? sample_i[QW-1:0] : '0;
  end

  always_comb begin
    case (rate_i)
      RATE_X2: placed = lane_x2;
      RATE_X4: placed = lane_x4;
      default: placed = sample_i;
    endcase
    pack_nxt = ((slot_q == 2'd0) ? '0 : pack_q) | placed;
    last     = (slot_q == last_slot(rate_i));
    go       = active_i & ((slot_q != 2'd0) | cont_i | qual_i);
  end

  assign we_o     = go & last;
  assign wdata_o  = pack_nxt;
  assign wstamp_o = (slot_q == 2'd0) ? ts_i : ts0_q;

  always_ff @(posedge clk) begin
    if (rst || start_i || !active_i) begin
      slot_q <= 2'd0;
      pack_q <= '0;
      ts0_q  <= '0;
    end else if (go) begin
      pack_q <= pack_nxt;
      if (slot_q == 2'd0) ts0_q <= ts_i;
      slot_q <= last ? 2'd0 : slot_q + 2'd1;
    end
  end

endmodule

// File: rtl/msc_ring_buf.sv
`timescale 1ns/1ps
module msc_ring_buf #(
  parameter int CH_W  = 32,
  parameter int TS_W  = 51,
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            active_i,
  input  logic            trig_i,
  input  logic            we_i,
  input  logic [CH_W-1:0] wdata_i,
  input  logic [TS_W-1:0] wstamp_i,
  input  logic [AW-1:0]   rd_addr_i,
  output logic [AW-1:0]   wr_ptr_o,
  output logic            wrapped_o,
  output logic            trig_seen_o,
  output logic [AW-1:0]   trig_addr_o,
  output logic [CH_W-1:0] rd_data_o,
  output logic [TS_W-1:0] rd_stamp_o
);

  localparam int EW = CH_W + TS_W;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [EW-1:0] mem [DEPTH];
  logic [EW-1:0] rd_q;
  logic [AW-1:0] wptr_q, taddr_q;
  logic          wrap_q, tseen_q;

  // Plain write port plus registered read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we_i) mem[wptr_q] <= {wstamp_i, wdata_i};
    rd_q <= mem[rd_addr_i];
  end

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      wptr_q  <= '0;
      wrap_q  <= 1'b0;
      tseen_q <= 1'b0;
      taddr_q <= '0;
    end else begin
      if (we_i) begin
        if (wptr_q == LAST) begin
          wptr_q <= '0;
          wrap_q <= 1'b1;
        end else begin
          wptr_q <= wptr_q + 1'b1;
        end
      end
      if (active_i && trig_i && !tseen_q) begin
        tseen_q <= 1'b1;
        taddr_q <= wptr_q;
      end
    end
  end

  assign wr_ptr_o    = wptr_q;
  assign wrapped_o   = wrap_q;
  assign trig_seen_o = tseen_q;
  assign trig_addr_o = taddr_q;
  assign rd_data_o   = rd_q[CH_W-1:0];
  assign rd_stamp_o  = rd_q[EW-1:CH_W];

endmodule

// File: rtl/msc_capture.sv
`timescale 1ns/1ps
module msc_capture
  import msc_pkg::*;
#(
  parameter int CH_W  = 32,
  parameter int TS_W  = 51,
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            arm_i,
  input  logic [1:0]      rate_i,
  input  logic            cont_i,
  input  logic            qual_i,
  input  logic            trig_i,
  input  logic [CH_W-1:0] sample_i,
  input  logic [AW-1:0]   rd_addr_i,
  output logic            running_o,
  output logic [AW-1:0]   wr_ptr_o,
  output logic            wrapped_o,
  output logic            trig_seen_o,
  output logic [AW-1:0]   trig_addr_o,
  output logic [CH_W-1:0] rd_data_o,
  output logic [TS_W-1:0] rd_stamp_o
);

  logic            start, active, wr_en;
  rate_e           rate_q;
  logic [TS_W-1:0] ts, wr_stamp;
  logic [CH_W-1:0] wr_data;

  msc_arm_ctrl #(.TS_W(TS_W)) u_ctrl (
    .clk(clk), .rst(rst), .arm_i(arm_i), .rate_i(rate_i),
    .start_o(start), .active_o(active), .running_o(running_o),
    .rate_o(rate_q), .ts_o(ts)
  );

  msc_lane_packer #(.CH_W(CH_W), .TS_W(TS_W)) u_pack (
    .clk(clk), .rst(rst), .start_i(start), .active_i(active),
    .rate_i(rate_q), .cont_i(cont_i), .qual_i(qual_i),
    .sample_i(sample_i), .ts_i(ts),
    .we_o(wr_en), .wdata_o(wr_data), .wstamp_o(wr_stamp)
  );

  msc_ring_buf #(.CH_W(CH_W), .TS_W(TS_W), .DEPTH(DEPTH), .AW(AW)) u_ring (
    .clk(clk), .rst(rst), .start_i(start), .active_i(active),
    .trig_i(trig_i), .we_i(wr_en), .wdata_i(wr_data), .wstamp_i(wr_stamp),
    .rd_addr_i(rd_addr_i), .wr_ptr_o(wr_ptr_o), .wrapped_o(wrapped_o),
    .trig_seen_o(trig_seen_o), .trig_addr_o(trig_addr_o),
    .rd_data_o(rd_data_o), .rd_stamp_o(rd_stamp_o)
  );

endmodule

// File: rtl/msc_capture_chk.sv
`timescale 1ns/1ps
module msc_capture_chk #(
  parameter int TS_W  = 51,
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input logic            clk,
  input logic            rst,
  input logic            active,
  input logic            running,
  input logic            we,
  input logic [1:0]      rate,
  input logic [TS_W-1:0] ts,
  input logic [AW-1:0]   wptr,
  input logic            tseen,
  input logic [AW-1:0]   taddr
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // R6: one tick per running clock, modulo 2^TS_W
  a_r6_ts_step: assert property (@(posedge clk) disable iff (rst)
    $past(active) |-> ts == $past(ts) + 1'b1);

  // R2: latched rate holds during a run
  a_r2_rate_hold: assert property (@(posedge clk) disable iff (rst)
    (running && $past(running)) |-> $stable(rate));

  // R1: no entry is written outside an active run
  a_r1_idle_no_write: assert property (@(posedge clk) disable iff (rst)
    !active |-> !we);

  // R4: double mode writes at most every second clock
  a_r4_x2_spacing: assert property (@(posedge clk) disable iff (rst)
    (we && rate == 2'd1) |=> !we);

  // R5: quadruple mode writes at most every fourth clock
  a_r5_x4_spacing: assert property (@(posedge clk) disable iff (rst)
    (we && rate == 2'd2) |=> !we ##1 !we ##1 !we);

  // R8: pointer advances by one per write and wraps at the top
  a_r8_ptr_step: assert property (@(posedge clk) disable iff (rst)
    $past(we) |-> wptr == (($past(wptr) == LAST) ? '0 : $past(wptr) + 1'b1));

  // R9: recorded trigger address stays put
  a_r9_trig_hold: assert property (@(posedge clk) disable iff (rst)
    (tseen && $past(tseen)) |-> $stable(taddr));

endmodule

bind msc_capture msc_capture_chk #(.TS_W(TS_W), .DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .active(active), .running(running_o), .we(wr_en),
  .rate(rate_q), .ts(ts), .wptr(wr_ptr_o), .tseen(trig_seen_o),
  .taddr(trig_addr_o)
);

// File: tb/msc_capture_test.sv
`timescale 1ns/1ps
module msc_capture_test;

  localparam int CH_W  = 32;
  localparam int TS_W  = 51;
  localparam int DEPTH = 2048;
  localparam int AW    = $clog2(DEPTH);
  localparam int HW    = CH_W / 2;
  localparam int QW    = CH_W / 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst, arm, cont, qual, trig;
  logic [1:0]      rate_in;
  logic [CH_W-1:0] samp;
  logic [AW-1:0]   rd_addr;
  logic            running, wrapped, tseen;
  logic [AW-1:0]   wr_ptr, taddr;
  logic [CH_W-1:0] rd_data;
  logic [TS_W-1:0] rd_stamp;

  msc_capture #(.CH_W(CH_W), .TS_W(TS_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .arm_i(arm), .rate_i(rate_in), .cont_i(cont),
    .qual_i(qual), .trig_i(trig), .sample_i(samp), .rd_addr_i(rd_addr),
    .running_o(running), .wr_ptr_o(wr_ptr), .wrapped_o(wrapped),
    .trig_seen_o(tseen), .trig_addr_o(taddr), .rd_data_o(rd_data),
    .rd_stamp_o(rd_stamp)
  );

  int errs = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  logic            m_arm_d = 0, m_run = 0, m_wrapped = 0, m_tseen = 0;
  logic [1:0]      m_rate = 0;
  logic [TS_W-1:0] m_ts = '0, m_ts0 = '0;
  int              m_slot = 0, m_written = 0;
  logic [CH_W-1:0] m_pack = '0;
  logic [AW-1:0]   m_wptr = '0, m_taddr = '0;
  logic [CH_W-1:0] md [DEPTH];
  logic [TS_W-1:0] ms [DEPTH];

  function automatic logic [1:0] eff_rate(logic [1:0] c);
    return (c == 2'd3) ? 2'd0 : c;
  endfunction

  function automatic int group_len(logic [1:0] r);
    return (r == 2'd0) ? 1 : (r == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [CH_W-1:0] place(logic [1:0] r, int slot, logic [CH_W-1:0] s);
    if (r == 2'd1) return CH_W'(s[HW-1:0]) << (slot * HW);
    if (r == 2'd2) return CH_W'(s[QW-1:0]) << (slot * QW);
    return s;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    if (rst) begin
      m_arm_d = 0; m_run = 0; m_rate = 0; m_ts = '0; m_slot = 0;
      m_wptr = '0; m_wrapped = 0; m_tseen = 0; m_taddr = '0;
      return;
    end
    if (arm && !m_arm_d) begin
      m_run = 1; m_rate = eff_rate(rate_in); m_ts = '0; m_slot = 0;
      m_wptr = '0; m_wrapped = 0; m_tseen = 0; m_taddr = '0; m_written = 0;
    end else if (!arm) begin
      m_run = 0; m_slot = 0;
    end else if (m_run) begin
      if (trig && !m_tseen) begin
        m_tseen = 1; m_taddr = m_wptr;
      end
      if (m_slot != 0 || cont || qual) begin
        if (m_slot == 0) begin
          m_pack = '0; m_ts0 = m_ts;
        end
        m_pack |= place(m_rate, m_slot, samp);
        if (m_slot == group_len(m_rate) - 1) begin
          md[m_wptr] = m_pack; ms[m_wptr] = m_ts0; m_written++;
          if (m_wptr == AW'(DEPTH - 1)) begin
            m_wptr = '0; m_wrapped = 1;
          end else m_wptr = m_wptr + 1'b1;
          m_slot = 0;
        end else m_slot++;
      end
      m_ts = m_ts + 1'b1;
    end
    m_arm_d = arm;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic check_status(string tag);
    chk({tag, " R1 running"}, 64'(running), 64'(m_run));
    chk({tag, " R8 wr_ptr"}, 64'(wr_ptr), 64'(m_wptr));
    chk({tag, " R8 wrapped"}, 64'(wrapped), 64'(m_wrapped));
    chk({tag, " R9 trig_seen"}, 64'(tseen), 64'(m_tseen));
    chk({tag, " R9 trig_addr"}, 64'(taddr), 64'(m_taddr));
  endtask

  task automatic readback(string tag, int lo, int hi);
    for (int i = lo; i < hi; i++) begin
      rd_addr = AW'(i);
      cyc();
      chk({tag, " R10 data"}, 64'(rd_data), 64'(md[i]));
      chk({tag, " R6 stamp"}, 64'(rd_stamp), 64'(ms[i]));
    end
  endtask

  // One acquisition: arm, n running clocks, then disarm.
  task automatic run(logic [1:0] code, logic c, int n, int qpct, int t1, int t2,
                     bit scramble_rate, string tag);
    arm = 1; rate_in = code; cont = c; qual = 0; trig = 0;
    cyc();
    check_status({tag, " arm"});
    for (int i = 0; i < n; i++) begin
      samp = $urandom;
      qual = (($urandom % 100) < qpct);
      trig = (i == t1) || (i == t2);
      if (scramble_rate) rate_in = 2'($urandom);
      cyc();
      check_status(tag);
    end
    arm = 0; trig = 0; qual = 0;
    cyc();
    check_status({tag, " disarm"});
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1; arm = 0; rate_in = 0; cont = 0; qual = 0; trig = 0;
    samp = '0; rd_addr = '0;
    @(negedge clk);
    repeat (3) cyc();
    rst = 0;
    cyc();
    check_status("reset");

    // R9: trigger while idle is ignored
    trig = 1; cyc(); trig = 0; cyc();
    chk("R9 idle trigger", 64'(tseen), 64'd0);

    // R3 full width, continuous, two triggers (second ignored)
    run(2'd0, 1'b1, 40, 0, 5, 20, 0, "R3 x1");
    readback("R3 x1", 0, m_written);
    chk("R6 stamp of entry 7", 64'(ms[7]), 64'd7);
    chk("R9 first trigger kept", 64'(taddr), 64'd5);

    // R4 double, qualified, rate_i scrambled mid-run (R2)
    run(2'd1, 1'b0, 81, 50, 10, 30, 1, "R4 x2 qual R7 R2");
    readback("R4 x2", 0, m_written);

    // R5 quadruple, continuous, arm dropped mid group
    run(2'd2, 1'b1, 43, 0, 7, -1, 0, "R5 x4");
    chk("R1 partial group discarded", 64'(wr_ptr), 64'd10);
    readback("R5 x4", 0, m_written);

    // R7 quadruple gated by qualifier
    run(2'd2, 1'b0, 60, 30, -1, -1, 0, "R7 x4 qual");
    readback("R7 x4", 0, m_written);

    // R2 code 3 behaves as full width
    run(2'd3, 1'b1, 12, 0, -1, -1, 0, "R2 code3");
    chk("R2 code3 entries", 64'(wr_ptr), 64'd12);
    readback("R2 code3", 0, m_written);

    // R8 wrap with trigger after wrap
    run(2'd0, 1'b1, DEPTH + 20, 0, DEPTH + 5, -1, 0, "R8 wrap");
    chk("R8 wrapped flag", 64'(wrapped), 64'd1);
    chk("R8 final pointer", 64'(wr_ptr), 64'd20);
    chk("R9 trigger after wrap", 64'(taddr), 64'd5);
    readback("R8 wrap", 0, 32);
    readback("R8 wrap top", DEPTH - 16, DEPTH);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule